// File: doc/BRIEF.md
# Blanked Pulse-Skipping Current Limiter

This block sits between a PWM modulator and the gate driver of a buck converter's high-side switch. It opens the gate drive once per switching cycle and reacts to a single-bit over-current comparator. For a fixed number of clocks after each turn-on, it ignores that comparator, because switching noise makes the reading unreliable.

The block behaves differently in its two operating phases.

- **Soft-start.** The block limits current pulse by pulse. An over-current turns the switch off at once and raises an adaptive skip count by one, up to a limit of seven. The block then holds the gate low for that many following switching cycles. Each cycle that ends blanking with the current below threshold lowers the count by one. Under a sustained short, the switching rate therefore falls to one eighth of nominal.
- **Regulation.** An over-current turns the switch off and sends a one-clock hiccup request to the soft-start sequencer. That sequencer zeroes the reference and ramps it again.

Top module: `oc_pulse_limiter`

## Requirements
- R1: After reset the gate drive, the hiccup request and the skip count are all 0.
- R2: In a cycle that is not skipped and has no over-current, the gate is high in every clock in which the on-request is high, counted from the clock after the cycle-start strobe.
- R3: A comparator that is high only within the first BLANK_CYC (default 20) clocks of the gate being high has no effect: the gate stays high, the skip count is not raised and no hiccup is issued.
- R4: In soft-start, a comparator that is high in the clock that ends blanking (the gate's BLANK_CYC+1-th high clock) makes that the last high clock of the gate, and the skip count rises by one.
- R5: After blanking, a comparator that is high in any clock while the gate is high makes that the last high clock of the gate.
- R6: After a soft-start trip, the gate stays low for as many following cycle-start strobes as the updated skip count. A cycle without a trip causes no skipping.
- R7: The skip count saturates at 7.
- R8: A cycle in which the comparator is low at the end of blanking lowers the skip count by one, but not below 0.
- R9: In regulation (soft-start flag low), a trip turns the gate off, produces a hiccup request exactly one clock wide, leaves the skip count unraised, and causes no skipping.
- R10: While the soft-start flag is high, no hiccup request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| pwm_on | input | 1 | On-request from the PWM comparator |
| oc_cmp | input | 1 | Over-current comparator output |
| ss_active | input | 1 | High while soft-start is ramping |
| gate_out | output | 1 | Gate drive to the power switch |
| hiccup_req | output | 1 | One-clock request to restart soft-start |
| skip_cnt | output | 3 | Current adaptive skip count |

## Verification
The hardest states to reach are saturation at seven and the interplay between the end-of-blanking decrement and a later trip in the same cycle. Both require a long chain of consecutive tripping cycles, each followed by exactly the right number of skipped strobes. The bench drives eight back-to-back soft-start trips, checking the skipped cycles after each one. It then places an over-current after blanking while the count is saturated, where a decrement and an increment cancel. Finally it switches to regulation to see a hiccup that leaves the count unraised.

// File: rtl/oc_limiter_pkg.sv
package oc_limiter_pkg;
  localparam int unsigned SKIP_MAX = 7;
  localparam int unsigned SKIP_W   = $clog2(SKIP_MAX + 1);

  typedef logic [SKIP_W-1:0] skip_t;

  function automatic skip_t skip_up(input skip_t v);
    return (v == skip_t'(SKIP_MAX)) ? v : v + skip_t'(1);
  endfunction

  function automatic skip_t skip_down(input skip_t v);
    return (v == '0) ? v : v - skip_t'(1);
  endfunction
endpackage

// File: rtl/oc_blank_timer.sv
module oc_blank_timer #(
  parameter int unsigned BLANK_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on,
  output logic sense_first,
  output logic sense_en
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 2);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC + 1);
  localparam logic [CW-1:0] EDGE = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!gate_on)            cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = cnt_q;
    else                     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sense_first = gate_on && (cnt_q == EDGE);
  assign sense_en    = gate_on && (cnt_q >= EDGE);

  // R3
  blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && $past(!gate_on)) |-> !sense_en);
endmodule

// File: rtl/oc_skip_ctrl.sv
module oc_skip_ctrl
  import oc_limiter_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trip_up,
  input  logic  clean_down,
  input  logic  cyc_start,
  output skip_t skip_cnt,
  output logic  skip_pending
);
  skip_t cnt_q, cnt_d;
  skip_t rem_q, rem_d;
  logic  upd_en;

  always_comb begin
    upd_en = trip_up | clean_down | cyc_start;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    if (trip_up)         cnt_d = skip_up(cnt_q);
    else if (clean_down) cnt_d = skip_down(cnt_q);
    if (trip_up)                       rem_d = skip_up(cnt_q);
    else if (cyc_start && rem_q != '0) rem_d = rem_q - skip_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rem_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      rem_q <= rem_d;
    end
  end

  assign skip_cnt     = cnt_q;
  assign skip_pending = (rem_q != '0);

  // R4
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + skip_t'(1)) ||
                                 (cnt_q + skip_t'(1) == $past(cnt_q))));
  // R7
  skip_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == skip_t'(SKIP_MAX) && $past(trip_up)) |-> (cnt_q == skip_t'(SKIP_MAX)));
  // R8
  skip_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0 && $past(clean_down)) |-> (cnt_q == '0));
endmodule

// File: rtl/oc_pulse_limiter.sv
module oc_pulse_limiter
  import oc_limiter_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              pwm_on,
  input  logic              oc_cmp,
  input  logic              ss_active,
  output logic              gate_out,
  output logic              hiccup_req,
  output logic [SKIP_W-1:0] skip_cnt
);
  logic  armed_q, armed_d;
  logic  pwm_q;
  logic  hic_q, hic_d;
  logic  sense_first, sense_en;
  logic  trip, clean, skip_pending;
  skip_t skip_val;

  assign gate_out = armed_q & pwm_on;

  oc_blank_timer #(.BLANK_CYC(BLANK_CYC)) blank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_on     (gate_out),
    .sense_first (sense_first),
    .sense_en    (sense_en)
  );

  assign trip  = sense_en & oc_cmp;
  assign clean = sense_first & ~oc_cmp;

  oc_skip_ctrl skip_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_up      (trip & ss_active),
    .clean_down   (clean),
    .cyc_start    (cyc_start),
    .skip_cnt     (skip_val),
    .skip_pending (skip_pending)
  );

  always_comb begin
    armed_d = armed_q;
    if (trip)                       armed_d = 1'b0;
    if (armed_q && pwm_q && !pwm_on) armed_d = 1'b0;
    if (cyc_start)                  armed_d = ~skip_pending;
    hic_d = trip & ~ss_active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pwm_q   <= 1'b0;
      hic_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pwm_q   <= pwm_on;
      hic_q   <= hic_d;
    end
  end

  assign hiccup_req = hic_q;
  assign skip_cnt   = skip_val;

  // R9
  hiccup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup_req |=> !hiccup_req);
  // R10
  hiccup_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup_req |-> !$past(ss_active));
  // R6
  skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && skip_pending) |=> !gate_out);
  // R5
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && sense_en && oc_cmp && !cyc_start) |=> !gate_out);
endmodule

// File: tb/oc_pulse_limiter_tb_top.sv
module oc_pulse_limiter_tb_top;
  localparam int BLANK = 20;
  localparam int LEN   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_start = 1'b0;
  logic       pwm_on = 1'b0;
  logic       oc_cmp = 1'b0;
  logic       ss_active = 1'b1;
  logic       gate_out;
  logic       hiccup_req;
  logic [2:0] skip_cnt;

  int checks = 0;
  int errors = 0;
  int gate_hi;
  int hic_seen;

  always #2 clk = ~clk;

  oc_pulse_limiter #(.BLANK_CYC(BLANK)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .pwm_on     (pwm_on),
    .oc_cmp     (oc_cmp),
    .ss_active  (ss_active),
    .gate_out   (gate_out),
    .hiccup_req (hiccup_req),
    .skip_cnt   (skip_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one switching cycle: oc high at steps [lo,hi]; step 1 is first gate clock
  task automatic run_cycle(input int lo, input int hi);
    gate_hi  = 0;
    hic_seen = 0;
    for (int s = 0; s <= LEN + 4; s++) begin
      @(negedge clk);
      if (s > 0) begin
        gate_hi  += int'(gate_out);
        hic_seen += int'(hiccup_req);
      end
      cyc_start = (s == 0);
      pwm_on    = (s < LEN);
      oc_cmp    = (s >= lo) && (s <= hi);
    end
    oc_cmp = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 gate", int'(gate_out), 0);
    check("R1 hiccup", int'(hiccup_req), 0);
    check("R1 skip", int'(skip_cnt), 0);
  endtask

  task automatic t_clean();
    run_cycle(1000, 0);
    check("R2 gate clocks", gate_hi, LEN);
    check("R8 floor skip", int'(skip_cnt), 0);
  endtask

  task automatic t_blank_ignore();
    run_cycle(1, BLANK);
    check("R3 gate clocks", gate_hi, LEN);
    check("R3 skip", int'(skip_cnt), 0);
    check("R3 hiccup", hic_seen, 0);
  endtask

  task automatic t_ss_trips();
    for (int n = 1; n <= 8; n++) begin
      int k;
      k = (n > 7) ? 7 : n;
      run_cycle(1, LEN);
      check("R4 gate clocks", gate_hi, BLANK + 1);
      check("R7 R4 skip", int'(skip_cnt), k);
      check("R10 hiccup", hic_seen, 0);
      for (int j = 0; j < k; j++) begin
        run_cycle(1000, 0);
        check("R6 skipped gate", gate_hi, 0);
      end
    end
  endtask

  task automatic t_late_trip();
    run_cycle(30, LEN);
    check("R5 gate clocks", gate_hi, 30);
    check("R5 R7 skip", int'(skip_cnt), 7);
    for (int j = 0; j < 7; j++) begin
      run_cycle(1000, 0);
      check("R6 skipped gate", gate_hi, 0);
    end
  endtask

  task automatic t_decrement();
    run_cycle(1000, 0);
    check("R8 gate clocks", gate_hi, LEN);
    check("R8 skip", int'(skip_cnt), 6);
    run_cycle(1000, 0);
    check("R6 no skip gate", gate_hi, LEN);
    check("R8 skip", int'(skip_cnt), 5);
  endtask

  task automatic t_regulation();
    ss_active = 1'b0;
    run_cycle(30, LEN);
    check("R9 gate clocks", gate_hi, 30);
    check("R9 hiccup", hic_seen, 1);
    check("R9 skip", int'(skip_cnt), 4);
    run_cycle(1000, 0);
    check("R9 no skip gate", gate_hi, LEN);
    check("R9 skip", int'(skip_cnt), 3);
    run_cycle(1, BLANK);
    check("R3 reg gate", gate_hi, LEN);
    check("R3 reg hiccup", hic_seen, 0);
    for (int j = 0; j < 3; j++) run_cycle(1000, 0);
    check("R8 skip zero", int'(skip_cnt), 0);
    run_cycle(1000, 0);
    check("R8 floor", int'(skip_cnt), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_blank_ignore();
        t_ss_trips();
        t_late_trip();
        t_decrement();
        t_regulation();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule